// File: doc/BRIEF.md
# Scan Line Channel Sequencer

This block turns a stream of valid pixel samples into a placement for each sample. For every sample it reports the output channel, the scan line inside the frame, and the horizontal pass. A frame holds eight passes of eighteen lines each, 144 lines in all. The eighteen channels take successive lines in round-robin order, and the sweep direction flips on each pass. The direction flag tells downstream logic which of the two modulators carries the pass.

The channels sit on three cards with six channels each, so the card number and the channel number inside the card are both reported. A one-hot write enable selects the buffer of the active channel. Single-cycle markers flag the last sample of a line, of a pass and of a frame.

A start-of-frame input realigns every counter to the frame origin. The line length is held in a writable register that resets to the full length of 262144 samples, which lets short lines be used when needed.

Top module: `scan_line_sequencer`

## Requirements
- R1: In the cycle after reset is released, the outputs read channel 0, card 0, local channel 0, line 0 and pass 0, with sweep flag 0. The write-enable vector and all three markers are low. The line-length register holds 262144.
- R2: The channel output equals the frame line number modulo 18. It moves to the next channel after the last sample of each line. While a sample is valid, buf_we_o has exactly bit [channel] set. Otherwise it is all zeros.
- R3: The card output is channel div 6 and the local output is channel mod 6.
- R4: The pass output is line div 18 and the line output is pass*18 + channel. The pass increments after channel 17 finishes.
- R5: The sweep flag is 0 (left to right, modulator A) on even passes and 1 (right to left, modulator B) on odd passes.
- R6: eol_o is high for exactly the cycle that carries the valid sample with index length-1 of a line. It is never high without a valid sample.
- R7: eop_o is high with eol_o on the last line of each pass (channel 17). eof_o is high with eol_o on line 143. The next sample after eof_o falls on line 0, pass 0, sample 0.
- R8: A start-of-frame that arrives with a valid sample places that sample at sample 0 of line 0, pass 0. A start-of-frame without a valid sample clears all counters, so the next valid sample takes that same place.
- R9: A cycle with no valid sample and no start-of-frame leaves the position unchanged. In such a cycle there is no marker and no write enable.
- R10: Writing the length register takes effect from the next cycle. Writing 0 stores 1, which makes every sample the end of its line. The register is 19 bits wide, so it can hold 262144.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid_i | input | 1 | A sample is present this cycle |
| sof_i | input | 1 | Start of frame; realigns counters |
| len_we_i | input | 1 | Write strobe for the line-length register |
| len_val_i | input | 19 | New line length in samples |
| chan_o | output | 5 | Active channel, 0..17 |
| card_o | output | 2 | Card holding the active channel |
| local_o | output | 3 | Channel index within its card |
| line_o | output | 8 | Line number within the frame, 0..143 |
| pass_o | output | 3 | Horizontal pass, 0..7 |
| sweep_rev_o | output | 1 | 1 when the pass sweeps right to left |
| buf_we_o | output | 18 | One-hot write enable to the channel buffers |
| eol_o | output | 1 | Last sample of a line |
| eop_o | output | 1 | Last sample of a pass |
| eof_o | output | 1 | Last sample of a frame |

## Verification
All placement outputs and markers are combinational from the position registers and the current inputs. They therefore describe the sample that is presented in the same cycle, with no added delay. The effect of that sample on the position appears one clock later. A length write counts from the cycle after its strobe.

The bench drives each sample just after a falling edge and compares one nanosecond later, before the next rising edge. It advances its own line and sample model only after the comparison. The comparison in each cycle is therefore checked against the position that was built up from earlier cycles alone.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
    localparam int NUM_CH      = 18;
    localparam int CH_PER_CARD = 6;
    localparam int NUM_PASS    = 8;
    localparam int LEN_W       = 19;
    localparam int DEFAULT_LEN = 262144;

    localparam int NUM_CARD = NUM_CH / CH_PER_CARD;
    localparam int NUM_LINE = NUM_CH * NUM_PASS;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int PASS_W   = $clog2(NUM_PASS);
    localparam int LINE_W   = $clog2(NUM_LINE);
    localparam int CARD_W   = $clog2(NUM_CARD);
    localparam int LOC_W    = $clog2(CH_PER_CARD);

    typedef enum logic {
        SWEEP_FWD = 1'b0,
        SWEEP_REV = 1'b1
    } sweep_e;

    typedef struct packed {
        logic [PASS_W-1:0] pass;
        logic [CH_W-1:0]   ch;
        logic [LEN_W-1:0]  smp;
    } scan_pos_t;

    function automatic sweep_e sweep_of(input logic [PASS_W-1:0] pass);
        return pass[0] ? SWEEP_REV : SWEEP_FWD;
    endfunction

    function automatic scan_pos_t advance(input scan_pos_t p, input logic line_end);
        scan_pos_t n;
        n = p;
        if (!line_end) begin
            n.smp = p.smp + LEN_W'(1);
        end else begin
            n.smp = '0;
            if (p.ch == CH_W'(NUM_CH - 1)) begin
                n.ch   = '0;
                n.pass = (p.pass == PASS_W'(NUM_PASS - 1)) ? '0 : p.pass + PASS_W'(1);
            end else begin
                n.ch = p.ch + CH_W'(1);
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/scan_len_reg.sv
module scan_len_reg
    import scan_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [LEN_W-1:0] val_i,
    output logic [LEN_W-1:0] len_o
);
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= LEN_W'(DEFAULT_LEN);
        end else if (we_i) begin
            len_q <= (val_i == '0) ? LEN_W'(1) : val_i;
        end
    end

    assign len_o = len_q;

    // R10: a stored length of zero would leave no line end
    assert_len_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
        len_q != '0);

    // R10: a write is visible the cycle after the strobe
    assert_len_write_R10: assert property (@(posedge clk) disable iff (rst)
        (we_i && val_i != '0) |=> (len_q == $past(val_i)));
endmodule

// File: rtl/scan_pos_ctr.sv
module scan_pos_ctr
    import scan_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic             sof_i,
    input  logic [LEN_W-1:0] len_i,
    output scan_pos_t        cur_o,
    output logic             eol_o,
    output logic             eop_o,
    output logic             eof_o
);
    scan_pos_t pos_q;
    scan_pos_t cur;
    logic      last_smp;

    always_comb begin
        cur      = sof_i ? '0 : pos_q;
        last_smp = (cur.smp >= len_i - LEN_W'(1));
        eol_o    = valid_i && last_smp;
        eop_o    = eol_o && (cur.ch == CH_W'(NUM_CH - 1));
        eof_o    = eop_o && (cur.pass == PASS_W'(NUM_PASS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (valid_i) begin
            pos_q <= advance(cur, last_smp);
        end else if (sof_i) begin
            pos_q <= '0;
        end
    end

    assign cur_o = cur;

    // R2: a finished line that is not the pass end moves to the next channel
    assert_chan_step_R2: assert property (@(posedge clk) disable iff (rst)
        (eol_o && !eop_o) |=> (sof_i || cur.ch == $past(cur.ch) + CH_W'(1)));

    // R7: after the frame end the origin follows
    assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        eof_o |=> (cur.ch == '0 && cur.pass == '0 && cur.smp == '0));

    // R9: an idle cycle keeps the position
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !sof_i) |=> (pos_q == $past(pos_q)));

    // R8: a start-of-frame with no sample clears the position
    assert_sof_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (sof_i && !valid_i) |=> (pos_q == '0));
endmodule

// File: rtl/scan_chan_map.sv
module scan_chan_map
    import scan_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  scan_pos_t         pos_i,
    output logic [NUM_CH-1:0] we_o,
    output logic [CARD_W-1:0] card_o,
    output logic [LOC_W-1:0]  local_o,
    output logic [LINE_W-1:0] line_o,
    output sweep_e            sweep_o
);
    logic [NUM_CARD-1:0] card_hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        assign we_o[c] = valid_i && (pos_i.ch == CH_W'(c));
    end

    for (genvar k = 0; k < NUM_CARD; k++) begin : g_card
        assign card_hit[k] = (pos_i.ch >= CH_W'(k * CH_PER_CARD)) &&
                             (pos_i.ch <  CH_W'((k + 1) * CH_PER_CARD));
    end

    always_comb begin
        card_o  = '0;
        local_o = '0;
        for (int k = 0; k < NUM_CARD; k++) begin
            if (card_hit[k]) begin
                card_o  = CARD_W'(k);
                local_o = LOC_W'(pos_i.ch - CH_W'(k * CH_PER_CARD));
            end
        end
    end

    assign line_o  = LINE_W'(pos_i.pass) * LINE_W'(NUM_CH) + LINE_W'(pos_i.ch);
    assign sweep_o = sweep_of(pos_i.pass);

    // R2: one buffer at most is written, and exactly one with a sample
    assert_we_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_o) && (valid_i == ($countones(we_o) == 1)));

    // R3: the channel falls inside exactly one card
    assert_card_unique_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(card_hit) == 1);
endmodule

// File: rtl/scan_line_sequencer.sv
module scan_line_sequencer
    import scan_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid_i,
    input  logic              sof_i,
    input  logic              len_we_i,
    input  logic [LEN_W-1:0]  len_val_i,
    output logic [CH_W-1:0]   chan_o,
    output logic [CARD_W-1:0] card_o,
    output logic [LOC_W-1:0]  local_o,
    output logic [LINE_W-1:0] line_o,
    output logic [PASS_W-1:0] pass_o,
    output logic              sweep_rev_o,
    output logic [NUM_CH-1:0] buf_we_o,
    output logic              eol_o,
    output logic              eop_o,
    output logic              eof_o
);
    logic [LEN_W-1:0] line_len;
    scan_pos_t        pos;
    sweep_e           sweep;

    scan_len_reg u_len (
        .clk   (clk),
        .rst   (rst),
        .we_i  (len_we_i),
        .val_i (len_val_i),
        .len_o (line_len)
    );

    scan_pos_ctr u_pos (
        .clk     (clk),
        .rst     (rst),
        .valid_i (pix_valid_i),
        .sof_i   (sof_i),
        .len_i   (line_len),
        .cur_o   (pos),
        .eol_o   (eol_o),
        .eop_o   (eop_o),
        .eof_o   (eof_o)
    );

    scan_chan_map u_map (
        .clk     (clk),
        .rst     (rst),
        .valid_i (pix_valid_i),
        .pos_i   (pos),
        .we_o    (buf_we_o),
        .card_o  (card_o),
        .local_o (local_o),
        .line_o  (line_o),
        .sweep_o (sweep)
    );

    assign chan_o      = pos.ch;
    assign pass_o      = pos.pass;
    assign sweep_rev_o = (sweep == SWEEP_REV);

    // R5: ending a pass inside a frame flips the sweep direction
    assert_sweep_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (eop_o && !eof_o) |=> (sof_i || sweep_rev_o != $past(sweep_rev_o)));

    // R7: frame end implies pass end, which implies line end
    assert_marker_nest_R7: assert property (@(posedge clk) disable iff (rst)
        (!eof_o || eop_o) && (!eop_o || eol_o));

    // R6: no marker without a sample
    assert_marker_valid_R6: assert property (@(posedge clk) disable iff (rst)
        eol_o |-> pix_valid_i);
endmodule

// File: tb/sim_scan_line_sequencer.sv
`timescale 1ns/1ps
module sim_scan_line_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_valid_i = 1'b0;
    logic        sof_i = 1'b0;
    logic        len_we_i = 1'b0;
    logic [18:0] len_val_i = '0;
    logic [4:0]  chan_o;
    logic [1:0]  card_o;
    logic [2:0]  local_o;
    logic [7:0]  line_o;
    logic [2:0]  pass_o;
    logic        sweep_rev_o;
    logic [17:0] buf_we_o;
    logic        eol_o, eop_o, eof_o;

    int total = 0;
    int bad = 0;
    int m_smp = 0;
    int m_line = 0;
    int m_len = 262144;
    bit finished = 0;

    always #2 clk = ~clk;

    scan_line_sequencer u0 (
        .clk(clk), .rst(rst), .pix_valid_i(pix_valid_i), .sof_i(sof_i),
        .len_we_i(len_we_i), .len_val_i(len_val_i),
        .chan_o(chan_o), .card_o(card_o), .local_o(local_o), .line_o(line_o),
        .pass_o(pass_o), .sweep_rev_o(sweep_rev_o), .buf_we_o(buf_we_o),
        .eol_o(eol_o), .eop_o(eop_o), .eof_o(eof_o)
    );

    // Drive one cycle, compare against the model, then advance the model.
    task automatic step(input bit v, input bit s, input string tag);
        logic [46:0] act, exp;
        int ch, ps;
        bit e_eol, e_eop, e_eof;
        logic [17:0] e_we;
        @(negedge clk);
        pix_valid_i = v; sof_i = s; len_we_i = 1'b0;
        #1;
        if (s) begin m_smp = 0; m_line = 0; end
        ch    = m_line % 18;
        ps    = m_line / 18;
        e_eol = v && (m_smp >= m_len - 1);
        e_eop = e_eol && (ch == 17);
        e_eof = e_eol && (m_line == 143);
        e_we  = v ? (18'd1 << ch) : 18'd0;
        exp = {5'(ch), 2'(ch / 6), 3'(ch % 6), 8'(m_line), 3'(ps), 1'(ps % 2),
               e_we, e_eol, e_eop, e_eof, 4'd0};
        act = {chan_o, card_o, local_o, line_o, pass_o, sweep_rev_o,
               buf_we_o, eol_o, eop_o, eof_o, 4'd0};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s line=%0d smp=%0d actual=%h expected=%h", tag, m_line, m_smp, act, exp);
        end
        if (v) begin
            if (m_smp >= m_len - 1) begin
                m_smp = 0;
                m_line = (m_line + 1) % 144;
            end else begin
                m_smp++;
            end
        end
    endtask

    task automatic write_len(input int val);
        @(negedge clk);
        pix_valid_i = 1'b0; sof_i = 1'b0; len_we_i = 1'b1; len_val_i = 19'(val);
        @(posedge clk);
        m_len = (val == 0) ? 1 : val;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_smp = 0; m_line = 0; m_len = 262144;
        step(0, 0, "R1");
    endtask

    task automatic t_default_len;
        // R10 / R1: the full-length default shows no line end early on
        for (int i = 0; i < 2000; i++) step(1, 0, "R10");
    endtask

    task automatic t_full_frame;
        // R2 R3 R4 R5 R6 R7: a whole frame with short lines, then wrap
        write_len(3);
        step(1, 1, "R8");
        for (int i = 0; i < 3 * 144 + 6; i++) step(1, 0, "R7");
    endtask

    task automatic t_idle_gaps;
        // R9: gaps keep the position and raise nothing
        for (int i = 0; i < 60; i++) step(i % 3 != 0, 0, "R9");
    endtask

    task automatic t_sof_mid;
        // R8: a start-of-frame with a sample mid-frame
        for (int i = 0; i < 100; i++) step(1, 0, "R4");
        step(1, 1, "R8");
        for (int i = 0; i < 10; i++) step(1, 0, "R8");
        // R8: a start-of-frame without a sample
        step(0, 1, "R8");
        for (int i = 0; i < 10; i++) step(1, 0, "R8");
    endtask

    task automatic t_len_zero;
        // R10: zero is stored as one, every sample ends a line
        write_len(0);
        for (int i = 0; i < 40; i++) step(1, 0, "R10");
        write_len(5);
        for (int i = 0; i < 40; i++) step(1, 0, "R10");
    endtask

    initial begin
        t_reset();
        t_default_len();
        t_full_frame();
        t_idle_gaps();
        t_sof_mid();
        t_len_zero();
        t_full_frame();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule